// File: doc/BRIEF.md
# Core Power-Up Sequencer

This block wakes one powered-down processor core. A single start pulse makes it step through a fixed sequence on the core's power-control outputs. The core is first held clamped and in reset. Then the power-gate head-switch is enabled with a programmed count. The memory clamp is released and the memory head-switch is turned on. After that the main clamp is released, both resets are dropped, and the core is finally flagged as powered up. Timed waits separate the steps. They are counted on a one-cycle microsecond tick from the surrounding clock tree, so the block needs no knowledge of the clock frequency.

The 8-bit control word and the 32-bit power-gate word are registered outputs that can be read back at any time. `busy_o` covers the whole sequence. `done_o` pulses once when the core is marked powered up. Every pin is plain control or status: no data stream passes through the block, so it has no valid/ready handshake. A start pulse that arrives while a sequence is running is dropped, not queued.

Top module: `core_wake_seq`

## Requirements
- R1: After reset, `ctrl_o` is 0x00, `pg_ctrl_o` is 0x00000000, and `busy_o` and `done_o` are low.
- R2: A start pulse while idle makes `ctrl_o` equal 0x33 in the next cycle and raises `busy_o`. 0x33 sets clamp (bit 0), memory clamp (bit 1), core reset (bit 4) and power-on reset (bit 5), and clears every other bit.
- R3: One cycle after R2, `pg_ctrl_o` becomes 0x10000001, which is enable in bit 0 and head-switch count 16 in bits 31:24. `ctrl_o` is unchanged.
- R4: On the second tick after the power-gate update, only the memory clamp (bit 1) clears, giving 0x31.
- R5: In the next cycle, with no wait, only the memory head-switch (bit 3) sets, giving 0x39. The head-switch is never on while the memory clamp is set.
- R6: On the second tick after R5, only the clamp (bit 0) clears, giving 0x38.
- R7: On the second tick after R6, core reset and power-on reset (bits 4 and 5) clear together, giving 0x08. The powered-up bit is never set while any clamp or reset bit is set.
- R8: In the next cycle the powered-up bit (bit 7) sets, giving 0x88. `done_o` is high for exactly that one cycle, and `busy_o` falls in the same cycle.
- R9: A tick counts toward a wait only if it is sampled after the update that opens the wait has taken effect. Ticks sampled in a non-waiting step are not counted.
- R10: A start pulse while `busy_o` is high has no effect on the sequence or its timing.
- R11: While idle, both output words hold their values. A new start pulse restarts from the R2 word, and the power-gate word is rewritten to the same value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | One-cycle request to begin the power-up sequence |
| us_tick_i | input | 1 | One-cycle pulse each microsecond |
| ctrl_o | output | 8 | Core power-control word |
| pg_ctrl_o | output | 32 | Power-gate control word |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle pulse when powered-up is set |

## Verification
The bench steps the sequence one cycle at a time and places ticks at the edges of each wait. A tick that lands on the power-gate update edge or on the head-switch step must not count. A design that counted it would release a clamp one microsecond early. Start pulses are driven in the middle of a wait. A design that honoured them would fall back to 0x33 or lengthen the wait. The bench also checks that both resets drop in one cycle, that `done_o` is a single-cycle pulse, and that a second run re-enters at 0x33 rather than keeping stale bits such as the head-switch.

// File: rtl/cws_pkg.sv
package cws_pkg;
  localparam int CTRL_W = 8;

  // bit positions of the core control word (fixed by the consumer)
  localparam int B_CLAMP    = 0;
  localparam int B_MEMCLAMP = 1;
  localparam int B_MEMHS    = 3;
  localparam int B_CORERST  = 4;
  localparam int B_PORRST   = 5;
  localparam int B_PWRUP    = 7;

  localparam logic [CTRL_W-1:0] INIT_WORD =
    CTRL_W'((1 << B_CLAMP) | (1 << B_MEMCLAMP) | (1 << B_CORERST) | (1 << B_PORRST));

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PGATE,
    ST_WAIT_MEM,
    ST_MEMHS,
    ST_WAIT_CLAMP,
    ST_WAIT_RST,
    ST_PWRUP
  } step_e;
endpackage

// File: rtl/cws_tick_wait.sv
module cws_tick_wait #(
  parameter int WAIT_TICKS = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  input  logic tick_i,
  output logic expire_o
);
  localparam int CW = $clog2(WAIT_TICKS + 1);

  logic [CW-1:0] cnt_q;

  assign expire_o = en_i && tick_i && (cnt_q == CW'(WAIT_TICKS - 1));

  always_ff @(posedge clk) begin
    if (!rst_n || !en_i || expire_o) cnt_q <= '0;
    else if (tick_i)                 cnt_q <= cnt_q + CW'(1);
  end

  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < CW'(WAIT_TICKS)); // R9
  AST_IDLE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> cnt_q == '0); // R9
endmodule

// File: rtl/cws_fsm.sv
module cws_fsm
  import cws_pkg::*;
#(
  parameter int PG_W    = 32,
  parameter int HS_CNT  = 16,
  parameter int CNT_LSB = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              expire_i,
  output logic              wait_en_o,
  output logic [CTRL_W-1:0] ctrl_o,
  output logic [PG_W-1:0]   pg_o,
  output logic              busy_o,
  output logic              done_o
);
  localparam logic [PG_W-1:0] PG_WORD = (PG_W'(HS_CNT) << CNT_LSB) | PG_W'(1);

  step_e             state_q;
  logic [CTRL_W-1:0] ctrl_q;
  logic [PG_W-1:0]   pg_q;
  logic              done_q;

  assign wait_en_o = (state_q == ST_WAIT_MEM) || (state_q == ST_WAIT_CLAMP) ||
                     (state_q == ST_WAIT_RST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      ctrl_q  <= '0;
      pg_q    <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        ST_IDLE: if (start_i) begin
          ctrl_q  <= INIT_WORD;
          state_q <= ST_PGATE;
        end
        ST_PGATE: begin
          pg_q    <= PG_WORD;
          state_q <= ST_WAIT_MEM;
        end
        ST_WAIT_MEM: if (expire_i) begin
          ctrl_q[B_MEMCLAMP] <= 1'b0;
          state_q            <= ST_MEMHS;
        end
        ST_MEMHS: begin
          ctrl_q[B_MEMHS] <= 1'b1;
          state_q         <= ST_WAIT_CLAMP;
        end
        ST_WAIT_CLAMP: if (expire_i) begin
          ctrl_q[B_CLAMP] <= 1'b0;
          state_q         <= ST_WAIT_RST;
        end
        ST_WAIT_RST: if (expire_i) begin
          ctrl_q[B_CORERST] <= 1'b0;
          ctrl_q[B_PORRST]  <= 1'b0;
          state_q           <= ST_PWRUP;
        end
        ST_PWRUP: begin
          ctrl_q[B_PWRUP] <= 1'b1;
          done_q          <= 1'b1;
          state_q         <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign ctrl_o = ctrl_q;
  assign pg_o   = pg_q;
  assign busy_o = (state_q != ST_IDLE);
  assign done_o = done_q;

  AST_START_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && start_i) |=> ctrl_o == INIT_WORD); // R2
  AST_HS_NEEDS_MEMREL: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_o[B_MEMHS] |-> !ctrl_o[B_MEMCLAMP]); // R5
  AST_PWRUP_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_o[B_PWRUP] |-> !(ctrl_o[B_CLAMP] || ctrl_o[B_MEMCLAMP] ||
                          ctrl_o[B_CORERST] || ctrl_o[B_PORRST])); // R7
  AST_RST_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_o[B_CORERST] == ctrl_o[B_PORRST]); // R7
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R8
  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o); // R8
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && !start_i) |=> ($stable(ctrl_o) && $stable(pg_o))); // R11
  AST_BUSY_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (wait_en_o && start_i && !expire_i) |=> $stable(ctrl_o)); // R10
endmodule

// File: rtl/core_wake_seq.sv
module core_wake_seq
  import cws_pkg::*;
#(
  parameter int WAIT_TICKS = 2,
  parameter int PG_W       = 32,
  parameter int HS_CNT     = 16,
  parameter int CNT_LSB    = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              us_tick_i,
  output logic [CTRL_W-1:0] ctrl_o,
  output logic [PG_W-1:0]   pg_ctrl_o,
  output logic              busy_o,
  output logic              done_o
);
  logic wait_en;
  logic expire;

  cws_tick_wait #(.WAIT_TICKS(WAIT_TICKS)) u_wait (
    .clk      (clk),
    .rst_n    (rst_n),
    .en_i     (wait_en),
    .tick_i   (us_tick_i),
    .expire_o (expire)
  );

  cws_fsm #(.PG_W(PG_W), .HS_CNT(HS_CNT), .CNT_LSB(CNT_LSB)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .expire_i  (expire),
    .wait_en_o (wait_en),
    .ctrl_o    (ctrl_o),
    .pg_o      (pg_ctrl_o),
    .busy_o    (busy_o),
    .done_o    (done_o)
  );
endmodule

// File: tb/test_core_wake_seq.sv
module test_core_wake_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic        us_tick_i = 1'b0;
  logic [7:0]  ctrl_o;
  logic [31:0] pg_ctrl_o;
  logic        busy_o;
  logic        done_o;
  int          total = 0;
  int          bad = 0;

  localparam logic [31:0] PGW = 32'h1000_0001;

  core_wake_seq i_core_wake_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .us_tick_i(us_tick_i),
    .ctrl_o(ctrl_o), .pg_ctrl_o(pg_ctrl_o), .busy_o(busy_o), .done_o(done_o)
  );

  always #5 clk = ~clk;

  task automatic cyc(input logic t, input logic s);
    us_tick_i = t;
    start_i   = s;
    @(posedge clk);
    #1;
    us_tick_i = 1'b0;
    start_i   = 1'b0;
  endtask

  task automatic chk(input string req, input logic [7:0] ec, input logic [31:0] ep,
                     input logic eb, input logic ed);
    total++;
    if (ctrl_o !== ec || pg_ctrl_o !== ep || busy_o !== eb || done_o !== ed) begin
      bad++;
      $display("FAIL %s: ctrl=%h pg=%h busy=%b done=%b expected ctrl=%h pg=%h busy=%b done=%b",
               req, ctrl_o, pg_ctrl_o, busy_o, done_o, ec, ep, eb, ed);
    end
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    cyc(0, 0); cyc(0, 0);
    rst_n = 1'b1;
    chk("R1 reset state", 8'h00, 32'h0, 1'b0, 1'b0);
  endtask

  task automatic t_full_sequence;
    cyc(0, 1);
    chk("R2 first word", 8'h33, 32'h0, 1'b1, 1'b0);
    cyc(0, 0);
    chk("R3 power-gate word", 8'h33, PGW, 1'b1, 1'b0);
    cyc(1, 0);
    chk("R4 one tick not enough", 8'h33, PGW, 1'b1, 1'b0);
    cyc(0, 0); cyc(0, 0); cyc(0, 0);
    chk("R4 idle cycles do not count", 8'h33, PGW, 1'b1, 1'b0);
    cyc(1, 0);
    chk("R4 memory clamp released", 8'h31, PGW, 1'b1, 1'b0);
    cyc(0, 0);
    chk("R5 head-switch on", 8'h39, PGW, 1'b1, 1'b0);
    cyc(1, 0);
    chk("R6 wait running", 8'h39, PGW, 1'b1, 1'b0);
    cyc(1, 0);
    chk("R6 clamp released", 8'h38, PGW, 1'b1, 1'b0);
    cyc(1, 0);
    chk("R7 wait running", 8'h38, PGW, 1'b1, 1'b0);
    cyc(1, 0);
    chk("R7 resets dropped together", 8'h08, PGW, 1'b1, 1'b0);
    cyc(0, 0);
    chk("R8 powered up, done pulse", 8'h88, PGW, 1'b0, 1'b1);
    cyc(0, 0);
    chk("R8 done is one cycle", 8'h88, PGW, 1'b0, 1'b0);
  endtask

  task automatic t_tick_alignment;
    cyc(0, 1);
    chk("R2 restart word", 8'h33, PGW, 1'b1, 1'b0);
    cyc(1, 0);
    chk("R9 tick on pg update edge", 8'h33, PGW, 1'b1, 1'b0);
    cyc(1, 0);
    chk("R9 first counted tick", 8'h33, PGW, 1'b1, 1'b0);
    cyc(1, 0);
    chk("R9 memory clamp after two counted", 8'h31, PGW, 1'b1, 1'b0);
    cyc(1, 0);
    chk("R9 tick on head-switch step", 8'h39, PGW, 1'b1, 1'b0);
    cyc(1, 0);
    chk("R9 first counted in clamp wait", 8'h39, PGW, 1'b1, 1'b0);
    cyc(1, 0);
    chk("R9 clamp released", 8'h38, PGW, 1'b1, 1'b0);
    cyc(1, 0); cyc(1, 0);
    chk("R9 resets dropped", 8'h08, PGW, 1'b1, 1'b0);
    cyc(1, 0);
    chk("R9 powered up", 8'h88, PGW, 1'b0, 1'b1);
  endtask

  task automatic t_busy_start;
    cyc(0, 1);
    cyc(0, 1);
    chk("R10 start during pg step", 8'h33, PGW, 1'b1, 1'b0);
    cyc(1, 1);
    cyc(0, 1);
    chk("R10 start during wait", 8'h33, PGW, 1'b1, 1'b0);
    cyc(1, 1);
    chk("R10 wait not lengthened", 8'h31, PGW, 1'b1, 1'b0);
    cyc(0, 1);
    chk("R10 head-switch unaffected", 8'h39, PGW, 1'b1, 1'b0);
    cyc(1, 1); cyc(1, 1); cyc(1, 1); cyc(1, 1);
    chk("R10 resets dropped", 8'h08, PGW, 1'b1, 1'b0);
    cyc(0, 1);
    chk("R10 powered up", 8'h88, PGW, 1'b0, 1'b1);
  endtask

  task automatic t_idle_hold;
    cyc(1, 0); cyc(1, 0); cyc(0, 0); cyc(1, 0);
    chk("R11 idle words hold", 8'h88, PGW, 1'b0, 1'b0);
    cyc(0, 1);
    chk("R11 restart clears old bits", 8'h33, PGW, 1'b1, 1'b0);
    cyc(0, 0);
    chk("R11 pg word rewritten", 8'h33, PGW, 1'b1, 1'b0);
    t_reset();
  endtask

  initial begin
    #1000000;
    bad++;
    total++;
    $display("FAIL watchdog: ran out of time, expected completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1;
    t_reset();
    t_full_sequence();
    t_tick_alignment();
    t_busy_start();
    t_idle_hold();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule